// File: doc/BRIEF.md
# Error Record Queue with Overflow Marker

This block stores error records in first-in first-out order until the host collects them. A record pairs a signed 16-bit error code with an 8-bit index that selects the text describing the error. Producers write one record per cycle with a push strobe. The oldest stored record is always shown on the head outputs, and the host removes it with a pop strobe. A not-empty output feeds the error-queue bit of the status byte.

When a push arrives while every slot is occupied and no pop is served in the same cycle, the incoming record is not stored. Instead, the newest stored record is replaced by a fixed overflow record, so the queue keeps its older history and ends with a marker showing that records were lost. After the marker is in place, further pushes are ignored until a pop frees a slot. A synchronous clear empties the queue.

Top module: `err_queue`

## Requirements
- R1: Records come out on `head_code`/`head_idx` in the order they were pushed.
- R2: The head record stays on the outputs until a pop is served. A served pop removes exactly that record.
- R3: A push on a full queue, with no pop served that cycle and no marker present, leaves the occupancy at DEPTH. It replaces the newest stored record with code -350 (16'hFEA2) and index OVF_IDX (default 8'hFF), and keeps all older records unchanged.
- R4: While the overflow marker is the newest record of a full queue, pushes without a pop change nothing. The marker is never written twice.
- R5: A pop on an empty queue is ignored. When the queue is empty, the head outputs read code 0 and index 0.
- R6: A push and a pop in the same cycle on a full queue remove the head and store the pushed record normally, with no overflow.
- R7: `not_empty` is 1 exactly when one or more records are stored. It drives bit 2 of the status byte.
- R8: `clr` empties the queue on the next clock edge and takes priority over push and pop in that cycle.
- R9: After reset the queue is empty and `not_empty` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all records |
| push_en | input | 1 | Push strobe |
| push_code | input | CODE_W | Error code to store, two's complement |
| push_idx | input | IDX_W | Description index to store |
| pop_en | input | 1 | Pop strobe from the host |
| head_code | output | CODE_W | Code of the oldest record, 0 when empty |
| head_idx | output | IDX_W | Index of the oldest record, 0 when empty |
| not_empty | output | 1 | At least one record is stored |

## Verification
The assertions assume that the strobes are clean single-bit levels sampled once per clock edge, and that reset is released synchronously to the clock. They make no assumption about how push and pop overlap, so every combination is legal. The bench changes inputs only at the falling edge. It runs directed sequences and then a long pseudo-random sweep on a depth-4 instance that mixes pushes, pops and occasional clears, so the full and empty boundaries are reached often.

// File: rtl/err_queue.sv
module err_queue #(
  parameter int DEPTH   = 8,
  parameter int CODE_W  = 16,
  parameter int IDX_W   = 8,
  parameter int OVF_VAL = -350,
  parameter logic [IDX_W-1:0] OVF_IDX = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push_en,
  input  logic [CODE_W-1:0] push_code,
  input  logic [IDX_W-1:0]  push_idx,
  input  logic              pop_en,
  output logic [CODE_W-1:0] head_code,
  output logic [IDX_W-1:0]  head_idx,
  output logic              not_empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CODE_W-1:0] OVF_CODE = CODE_W'(OVF_VAL);

  logic [CODE_W-1:0] code_mem [DEPTH];
  logic [IDX_W-1:0]  idx_mem  [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, last_ptr;
  logic [CW-1:0] cnt;
  logic ovf_mark;
  logic full, do_pop, do_push, do_ovf;

  assign full     = (cnt == FULL_CNT);
  assign do_pop   = pop_en && (cnt != '0);
  assign do_push  = push_en && (!full || do_pop);
  assign do_ovf   = push_en && full && !do_pop && !ovf_mark;
  assign last_ptr = (wr_ptr == '0) ? LAST_PTR : wr_ptr - 1'b1;

  assign not_empty = (cnt != '0);
  assign head_code = not_empty ? code_mem[rd_ptr] : '0;
  assign head_idx  = not_empty ? idx_mem[rd_ptr]  : '0;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      ovf_mark <= 1'b0;
    end else if (clr) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      ovf_mark <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (do_ovf)  ovf_mark <= 1'b1;
      else if (do_pop) ovf_mark <= 1'b0;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!clr && do_push) begin
      code_mem[wr_ptr] <= push_code;
      idx_mem[wr_ptr]  <= push_idx;
    end else if (!clr && do_ovf) begin
      code_mem[last_ptr] <= OVF_CODE;
      idx_mem[last_ptr]  <= OVF_IDX;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);

  p_overflow_marker_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && push_en && !pop_en && full && !ovf_mark)
    |=> (ovf_mark && full && $stable(rd_ptr) && $stable(wr_ptr)));

  p_discard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && push_en && !pop_en && full && ovf_mark)
    |=> (full && $stable(head_code) && $stable(head_idx) && $stable(wr_ptr)));

  p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !push_en && !not_empty) |=> !not_empty);

  p_full_push_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && push_en && pop_en && full) |=> (full && !ovf_mark));

  p_push_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && push_en) |=> not_empty);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!not_empty && head_code == '0 && head_idx == '0));
endmodule

// File: tb/err_queue_tb.sv
module err_queue_tb;
  localparam int D = 4;
  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, push_en = 1'b0, pop_en = 1'b0;
  logic [15:0] push_code = '0;
  logic [7:0]  push_idx = '0;
  logic [15:0] head_code;
  logic [7:0]  head_idx;
  logic        not_empty;
  int n_chk = 0, n_bad = 0;
  logic [23:0] mq [D];
  int mcnt = 0;
  bit mmark = 1'b0;
  logic [15:0] ovf_code;

  always #10 clk = ~clk;

  err_queue #(.DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push_en(push_en),
    .push_code(push_code), .push_idx(push_idx), .pop_en(pop_en),
    .head_code(head_code), .head_idx(head_idx), .not_empty(not_empty));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    logic [23:0] e;
    e = (mcnt > 0) ? mq[0] : 24'h0;
    chk(tag, {8'h0, head_code, head_idx}, {8'h0, e});
    chk("R7", 32'(not_empty), 32'(mcnt > 0));
  endtask

  task automatic step(input bit c, input bit pu, input logic [15:0] cd,
                      input logic [7:0] ix, input bit po);
    string tag;
    @(negedge clk);
    clr = c; push_en = pu; push_code = cd; push_idx = ix; pop_en = po;
    @(posedge clk);
    tag = "R1";
    if (c) begin
      mcnt = 0; mmark = 0; tag = "R8";
    end else begin
      if (po && mcnt == 0 && !pu) tag = "R5";
      if (pu && po && mcnt == D) tag = "R6";
      if (po && mcnt > 0) begin
        for (int i = 0; i < D - 1; i++) mq[i] = mq[i+1];
        mcnt--; mmark = 0;
        if (tag == "R1") tag = "R2";
      end
      if (pu) begin
        if (mcnt < D) begin
          mq[mcnt] = {cd, ix}; mcnt++;
        end else if (!mmark) begin
          mq[D-1] = {ovf_code, 8'hFF}; mmark = 1; tag = "R3";
        end else tag = "R4";
      end
    end
    #2;
    compare(tag);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    ovf_code = 16'(-350);
    #35;
    chk("R9", 32'(not_empty), 0);
    chk("R9", {8'h0, head_code, head_idx}, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 1);
    for (int k = 1; k <= D; k++) step(0, 1, 16'(k * 100), 8'(k), 0);
    step(0, 0, 0, 0, 0);
    step(0, 1, 16'h7777, 8'h11, 0);
    chk("R3", {8'h0, head_code, head_idx}, {8'h0, 16'd100, 8'd1});
    step(0, 1, 16'h8888, 8'h22, 0);
    step(0, 1, 16'h9999, 8'h33, 0);
    for (int k = 0; k < D; k++) step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    for (int k = 1; k <= D; k++) step(0, 1, 16'(-k), 8'(k), 0);
    step(0, 1, 16'h1234, 8'h56, 1);
    step(0, 1, 16'h2345, 8'h67, 1);
    step(1, 1, 16'h3456, 8'h78, 1);
    step(0, 1, 16'h4567, 8'h89, 1);
    step(0, 0, 0, 0, 1);
    lf = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      bit pu, po, cl;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      pu = (n[8]) ? (lf[2:0] != 0) : (lf[2:0] == 0);
      po = (n[8]) ? (lf[5:3] == 0) : (lf[5:3] != 0);
      cl = (lf[15:9] == 0);
      step(cl, pu, lf ^ 16'h5A5A, lf[7:0] ^ 8'(n), po);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule